// File: doc/BRIEF.md
# Shared-to-Local Long Copy Engine

This block fills a core's local register RAM from shared main memory. Software programs three values with single-cycle command writes: where the copy lands in local RAM, where it comes from in shared memory, and how many 32-bit longs it covers. Programming the length launches a copy. The engine then requests the shared memory and takes one long in every cycle in which the slot arbiter grants it a window. Each long is written into local RAM in that same cycle, and both pointers then advance by one.

The destination pointer and the length are kept after a copy ends. A later copy of the same size, landing in the same place, therefore needs only one command carrying the new shared source address. A busy flag covers the whole copy, and a one-cycle done pulse marks its end. Commands that arrive during a copy are discarded. The local RAM has a synchronous read port, so the core can read the filled words back.

Top module: `lcp_copy_engine`

## Requirements
- R1: The command field `cmd_op` selects the target. 0 loads the local destination pointer from `cmd_data[8:0]`. 1 loads the shared source pointer from `cmd_data[16:0]`. 2 loads the long count from `cmd_data[9:0]`. 3 changes nothing and starts nothing.
- R2: An accepted count command starts a copy. For a nonzero count, `busy` and `shr_req` are high from the clock edge that accepts the command.
- R3: A long moves only on a clock edge where `busy` and `shr_grant` are both high, and exactly one long moves on each such edge. While `shr_grant` is low, `shr_addr` holds and the copy waits.
- R4: `shr_addr` begins at the programmed source pointer and increases by one, modulo 2^17, after each long moves.
- R5: Long k of a copy lands at local address (destination + k) mod 512.
- R6: `busy` falls on the edge that writes the last long. `done` is high for exactly the cycle after that edge, and `busy` is low in that cycle.
- R7: A copy with a count of zero raises `done` on the edge that accepts the command. It never raises `busy` or `shr_req`.
- R8: The destination pointer and the count persist. An accepted source command starts a new copy that uses the stored count and the stored destination.
- R9: While `busy` is high, commands are ignored: no pointer or count changes.
- R10: `rd_data` returns the local RAM word at `rd_addr` one clock edge later.
- R11: After reset, `busy`, `done` and `shr_req` are low, and the pointers and count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_op | input | 2 | Command target select |
| cmd_data | input | 32 | Command value |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| shr_req | output | 1 | Shared memory window request |
| shr_addr | output | 17 | Shared long address for the current transfer |
| shr_grant | input | 1 | Window granted this cycle; `shr_rdata` is valid |
| shr_rdata | input | 32 | Shared memory read data for `shr_addr` |
| rd_addr | input | 9 | Local RAM read address |
| rd_data | output | 32 | Local RAM read data, one cycle after `rd_addr` |

## Verification
Commands are driven on falling edges, so the rising edge after a command is the one that accepts it. `busy`, or `done` for a zero count, is therefore checked at the next falling edge. The grant is driven one nanosecond after each rising edge and counted at the falling edge before the rising edge that consumes it. This gives the number of longs moved and the expected `shr_addr` for each of them. `done` is checked at the first falling edge after the last counted grant and checked low one cycle later. Read-back data is taken one falling edge after `rd_addr` is applied, which matches the single registered read stage.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  typedef enum logic [1:0] {
    OP_DST = 2'd0,
    OP_SRC = 2'd1,
    OP_CNT = 2'd2,
    OP_NOP = 2'd3
  } lcp_op_e;
endpackage

// File: rtl/lcp_cmd_regs.sv
module lcp_cmd_regs
  import lcp_pkg::*;
#(
  parameter int LOC_AW = 9,
  parameter int SA_W   = 17,
  parameter int CNT_W  = 10,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DW-1:0]     cmd_data,
  input  logic              eng_busy,
  output logic              start,
  output logic [LOC_AW-1:0] start_dst,
  output logic [SA_W-1:0]   start_src,
  output logic [CNT_W-1:0]  start_cnt
);
  logic [LOC_AW-1:0] dst_q;
  logic [SA_W-1:0]   src_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              accept;
  lcp_op_e           op;

  assign op     = lcp_op_e'(cmd_op);
  assign accept = cmd_valid && !eng_busy;

  always_comb begin
    start     = accept && (op == OP_SRC || op == OP_CNT);
    start_dst = dst_q;
    start_src = (op == OP_SRC) ? cmd_data[SA_W-1:0] : src_q;
    start_cnt = (op == OP_CNT) ? cmd_data[CNT_W-1:0] : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q <= '0;
      src_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      case (op)
        OP_DST:  dst_q <= cmd_data[LOC_AW-1:0];
        OP_SRC:  src_q <= cmd_data[SA_W-1:0];
        OP_CNT:  cnt_q <= cmd_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> ($stable(dst_q) && $stable(src_q) && $stable(cnt_q))); // R9
  AST_NOP_INERT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_NOP) |=> ($stable(dst_q) && $stable(src_q) && $stable(cnt_q))); // R1
endmodule

// File: rtl/lcp_xfer_ctrl.sv
module lcp_xfer_ctrl #(
  parameter int LOC_AW = 9,
  parameter int SA_W   = 17,
  parameter int CNT_W  = 10,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LOC_AW-1:0] start_dst,
  input  logic [SA_W-1:0]   start_src,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              shr_grant,
  input  logic [DW-1:0]     shr_rdata,
  output logic              busy,
  output logic              done,
  output logic [SA_W-1:0]   shr_addr,
  output logic              wr_en,
  output logic [LOC_AW-1:0] wr_addr,
  output logic [DW-1:0]     wr_data
);
  logic [SA_W-1:0]   cur_src;
  logic [LOC_AW-1:0] cur_dst;
  logic [CNT_W-1:0]  remain;
  logic              take;

  assign take     = busy && shr_grant;
  assign shr_addr = cur_src;
  assign wr_en    = take;
  assign wr_addr  = cur_dst;
  assign wr_data  = shr_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      remain  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        cur_src <= start_src;
        cur_dst <= start_dst;
        remain  <= start_cnt;
        if (start_cnt == '0) done <= 1'b1;
        else                 busy <= 1'b1;
      end else if (take) begin
        cur_src <= cur_src + 1'b1;
        cur_dst <= cur_dst + 1'b1;
        remain  <= remain - 1'b1;
        if (remain == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (busy && !shr_grant) |=> ($stable(cur_src) && $stable(remain) && busy)); // R3
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (take && remain > CNT_W'(1)) |=> (cur_src == SA_W'($past(cur_src) + 1'b1))); // R4
  AST_DST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (take && remain > CNT_W'(1)) |=> (cur_dst == LOC_AW'($past(cur_dst) + 1'b1))); // R5
  AST_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && start_cnt == '0) |=> (done && !busy)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && start_cnt != '0) |=> busy); // R2
endmodule

// File: rtl/lcp_local_ram.sv
module lcp_local_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcp_copy_engine.sv
module lcp_copy_engine #(
  parameter int LOC_DEPTH = 512,
  parameter int SA_W      = 17,
  parameter int CNT_W     = 10,
  parameter int DW        = 32,
  localparam int LOC_AW   = $clog2(LOC_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DW-1:0]     cmd_data,
  output logic              busy,
  output logic              done,
  output logic              shr_req,
  output logic [SA_W-1:0]   shr_addr,
  input  logic              shr_grant,
  input  logic [DW-1:0]     shr_rdata,
  input  logic [LOC_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  logic              start;
  logic [LOC_AW-1:0] start_dst;
  logic [SA_W-1:0]   start_src;
  logic [CNT_W-1:0]  start_cnt;
  logic              wr_en;
  logic [LOC_AW-1:0] wr_addr;
  logic [DW-1:0]     wr_data;

  lcp_cmd_regs #(.LOC_AW(LOC_AW), .SA_W(SA_W), .CNT_W(CNT_W), .DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .eng_busy(busy), .start(start),
    .start_dst(start_dst), .start_src(start_src), .start_cnt(start_cnt)
  );

  lcp_xfer_ctrl #(.LOC_AW(LOC_AW), .SA_W(SA_W), .CNT_W(CNT_W), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_dst(start_dst),
    .start_src(start_src), .start_cnt(start_cnt), .shr_grant(shr_grant),
    .shr_rdata(shr_rdata), .busy(busy), .done(done), .shr_addr(shr_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  lcp_local_ram #(.DEPTH(LOC_DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign shr_req = busy;

  AST_REQ_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !shr_req); // R7
endmodule

// File: tb/lcp_copy_engine_tb.sv
module lcp_copy_engine_tb_top;
  localparam int NV = 4;
  localparam int VD [NV] = '{0, 40, 200, 300};
  localparam int VS [NV] = '{100, 131070, 777, 5000};
  localparam int VC [NV] = '{8, 5, 1, 16};
  localparam int VG [NV] = '{1, 3, 2, 4};

  logic clk = 0;
  logic rst = 1;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [31:0] cmd_data = 0;
  logic busy, done, shr_req;
  logic [16:0] shr_addr;
  logic shr_grant = 0;
  logic [31:0] shr_rdata;
  logic [8:0] rd_addr = 0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  int gap = 1;
  bit hold_off = 0;
  int tick = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] shm(input logic [16:0] a);
    return 32'h5A5A0000 ^ (32'(a) * 32'h9E3779B1);
  endfunction

  assign shr_rdata = shm(shr_addr);

  lcp_copy_engine dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .shr_req(shr_req),
    .shr_addr(shr_addr), .shr_grant(shr_grant), .shr_rdata(shr_rdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      shr_grant = !hold_off && ((tick % gap) == 0);
      tick++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(input logic [16:0] src0, output int xfers, output bit seq_ok,
                           output bit done_ok);
    int guard = 0;
    xfers = 0; seq_ok = 1; done_ok = 1;
    while (!done && guard < 5000) begin
      if (busy && shr_grant) begin
        if (shr_addr !== 17'(src0 + 17'(xfers))) seq_ok = 0;
        xfers++;
      end
      @(negedge clk);
      guard++;
    end
    if (busy) done_ok = 0;
    @(negedge clk);
    if (done) done_ok = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_region(input string req, input int dst, input int src, input int n);
    logic [31:0] v;
    bit ok = 1;
    logic [31:0] bad_a = 0, bad_e = 0;
    for (int k = 0; k < n; k++) begin
      rd(9'(dst + k), v);
      if (v !== shm(17'(src + k)) && ok) begin
        ok = 0; bad_a = v; bad_e = shm(17'(src + k));
      end
    end
    chk(req, ok ? 32'd0 : bad_a, ok ? 32'd0 : bad_e);
  endtask

  initial begin
    int x; bit sq, dn;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 shr_req", shr_req, 0);

    // R7: count is zero after reset, source command starts an empty copy
    cmd(2'd1, 32'd55);
    chk("R7 done on src with zero count", done, 1);
    chk("R7 busy stays low", busy, 0);
    chk("R7 no request", shr_req, 0);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    cmd(2'd2, 32'd0);
    chk("R7 done on zero count", {busy, done}, 2'b01);
    @(negedge clk);

    // Vector table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      gap = VG[i];
      cmd(2'd0, 32'(VD[i]));
      cmd(2'd1, 32'(VS[i]));
      wait_done(17'(VS[i]), x, sq, dn);
      cmd(2'd2, 32'(VC[i]));
      chk("R2 busy after count", busy, 1);
      chk("R2 request after count", shr_req, 1);
      wait_done(17'(VS[i]), x, sq, dn);
      chk("R3 longs moved", 32'(x), 32'(VC[i]));
      chk("R4 address sequence", 32'(sq), 1);
      chk("R6 done pulse", 32'(dn), 1);
      check_region("R10 R5 data", VD[i], VS[i], VC[i]);
    end

    // R8: source-only copy reuses count 16 and destination 300
    cmd(2'd1, 32'd9000);
    chk("R8 busy on src only", busy, 1);
    wait_done(17'd9000, x, sq, dn);
    chk("R8 stored count used", 32'(x), 32'd16);
    check_region("R8 stored destination used", 300, 9000, 16);

    // R9: commands during a copy are ignored
    gap = 4;
    cmd(2'd1, 32'd12000);
    cmd(2'd0, 32'd50);
    cmd(2'd2, 32'd3);
    cmd(2'd1, 32'd1);
    chk("R9 still busy", busy, 1);
    wait_done(17'd12000, x, sq, dn);
    check_region("R9 copy undisturbed", 300, 12000, 16);
    cmd(2'd1, 32'd13000);
    wait_done(17'd13000, x, sq, dn);
    chk("R9 count unchanged", 32'(x), 32'd16);
    check_region("R9 destination unchanged", 300, 13000, 16);

    // R1: op 3 has no effect
    cmd(2'd3, 32'd7);
    chk("R1 op3 no start", {busy, done}, 2'b00);
    cmd(2'd1, 32'd14000);
    wait_done(17'd14000, x, sq, dn);
    chk("R1 op3 left count", 32'(x), 32'd16);
    check_region("R1 op3 left destination", 300, 14000, 16);

    // R5 wrap across the top of local RAM
    gap = 1;
    cmd(2'd0, 32'd510);
    cmd(2'd1, 32'd15000);
    wait_done(17'd15000, x, sq, dn);
    cmd(2'd2, 32'd4);
    wait_done(17'd15000, x, sq, dn);
    chk("R5 wrap count", 32'(x), 32'd4);
    check_region("R5 wrap data", 510, 15000, 4);

    // R3: no grant, no progress
    hold_off = 1;
    cmd(2'd1, 32'd20000);
    begin
      bit held = 1;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (!busy || shr_addr !== 17'd20000) held = 0;
      end
      chk("R3 stalls without grant", 32'(held), 1);
    end
    hold_off = 0;
    wait_done(17'd20000, x, sq, dn);
    chk("R3 resumes after grant", 32'(x), 32'd4);
    check_region("R3 data after stall", 510, 20000, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule